// File: doc/BRIEF.md
# Watchdog Timer with Early-Warning Interrupt

This block is a free-running watchdog counter that is clocked straight from the system clock. A two-bit select picks one of four power-of-two interval lengths. When the count reaches the chosen interval, a sticky warning flag is set. A fixed 512 clocks later, a sticky expiry flag is set. If the reset function is armed, a single-cycle CPU reset pulse is also issued. Firmware keeps the system alive by restarting the counter before the expiry point.

The restart strobe and the reset-arm bit cannot be changed by an ordinary store. A protected write only lands inside a short window. That window is opened by writing two key bytes back to back to the key address on the write port. The warning and expiry flags are cleared by write-one-to-clear without any unlock. The interrupt output and the reset pulse are gated independently, so either one can be used without the other.

A `SCALE` parameter subtracts a constant from all four exponents. This lets a bench exercise every interval in short runs, while the 512-clock warning gap keeps its full length.

Top module: `wdog_top`

## Requirements
- R1: With select value 0, 1, 2 or 3 (config register bits [1:0]), the warning flag rises exactly 2^(17-SCALE), 2^(20-SCALE), 2^(23-SCALE) or 2^(26-SCALE) clocks after the restart edge.
- R2: Without an intervening restart, the expiry flag rises exactly GAP (512) clocks after the warning flag's set point.
- R3: `irq_o` is high only while the warning flag is set and the interrupt enable (config register bit 2) is 1. The flag itself is set whatever the enable is.
- R4: At the expiry point, `wdt_rst_o` pulses for exactly one clock, and only if the reset-arm bit is 1. The same edge clears the counter and the reset-arm bit. The expiry flag is set either way.
- R5: A restart (protected register bit 0 = 1) clears the counter, so the next warning comes a full interval after the restart edge.
- R6: A write to the protected register (address 2) outside an open window has no effect on the reset-arm bit or the counter.
- R7: Writing 0xAA and then 0x55 to address 0 on consecutive clocks opens the window for the next 3 clocks. Any other write in between, including the protected write itself, closes it. A protected write on the 4th clock is ignored.
- R8: Writing 1 to bit 0 or bit 1 of address 3 clears the warning or the expiry flag, with no unlock needed. A set in the same clock takes priority over the clear.
- R9: After reset, both flags, `irq_o`, `wdt_rst_o` and the reset-arm bit are 0. The select is 0 and the interrupt enable is 0.
- R10: In the protected register, bit 1 = 1 arms the reset and bit 2 = 1 disarms it, with disarm taking priority. `rst_en_o` shows the arm bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, also the watchdog time base |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 key, 1 config, 2 protected, 3 flag clear |
| wr_data_i | input | 8 | Write data |
| irq_o | output | 1 | Warning interrupt request (flag AND enable) |
| irq_flag_o | output | 1 | Sticky warning flag |
| rst_flag_o | output | 1 | Sticky expiry flag |
| rst_en_o | output | 1 | Reset-arm bit |
| wdt_rst_o | output | 1 | One-clock CPU reset pulse |

## Verification
Several properties are checked on every clock:
- the reset pulse lasts one clock and leaves a zero count;
- a restart zeroes the count;
- the interrupt output never rises without its enable;
- the arm bit changes only after an accepted protected write or a pulse;
- a window opens only after the second key byte.

The exact interval lengths for each select value, the 512-clock gap, the window's three-clock boundary and set-over-clear priority depend on exact cycle positions. Only the bench's timed scenarios can show those.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int EXP_BASE = 17;
  localparam int EXP_STEP = 3;
  localparam int EXP_TOP  = EXP_BASE + 3 * EXP_STEP;

  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;

  localparam logic [1:0] ADDR_KEY  = 2'd0;
  localparam logic [1:0] ADDR_CFG  = 2'd1;
  localparam logic [1:0] ADDR_PROT = 2'd2;
  localparam logic [1:0] ADDR_CLR  = 2'd3;

  function automatic int tmo_exp(input logic [1:0] sel, input int scale);
    return EXP_BASE + EXP_STEP * int'(sel) - scale;
  endfunction
endpackage

// File: rtl/wdog_unlock.sv
module wdog_unlock
  import wdog_pkg::*;
#(
  parameter int WIN = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [1:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  output logic       open_o
);
  localparam int OPEN_W = $clog2(WIN + 1);

  logic              armed_q;
  logic [OPEN_W-1:0] open_cnt_q;
  logic              key_wr;

  assign key_wr = wr_en_i && (wr_addr_i == ADDR_KEY);
  assign open_o = (open_cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q    <= 1'b0;
      open_cnt_q <= '0;
    end else begin
      armed_q <= key_wr && (wr_data_i == KEY_FIRST);
      if (wr_en_i) begin
        // second key byte must directly follow the first
        if (key_wr && armed_q && (wr_data_i == KEY_SECOND)) open_cnt_q <= OPEN_W'(WIN);
        else                                                open_cnt_q <= '0;
      end else if (open_cnt_q != '0) begin
        open_cnt_q <= open_cnt_q - 1'b1;
      end
    end
  end

  // R7
  open_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(open_o) |-> $past(key_wr && wr_data_i == KEY_SECOND));

  // R7
  write_closes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !key_wr) |=> !open_o);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int SCALE = 0,
  parameter int GAP   = 512
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] sel_i,
  input  logic       restart_i,
  input  logic       rst_en_i,
  input  logic       clr_irq_i,
  input  logic       clr_rst_i,
  output logic       fire_o,
  output logic       irq_flag_o,
  output logic       rst_flag_o,
  output logic       wdt_rst_o
);
  localparam int EXP_MAX = EXP_TOP - SCALE;
  localparam int CNT_W   = $clog2((1 << EXP_MAX) + GAP) + 1;

  logic [CNT_W-1:0] cnt_q, irq_lim, rst_lim;
  logic             irq_hit, rst_hit;
  logic             irq_flag_q, rst_flag_q, pulse_q;

  always_comb begin
    irq_lim = CNT_W'(1) << tmo_exp(sel_i, SCALE);
    rst_lim = irq_lim + CNT_W'(GAP);
  end

  assign irq_hit = !restart_i && (cnt_q == irq_lim - CNT_W'(1));
  assign rst_hit = !restart_i && (cnt_q == rst_lim - CNT_W'(1));
  assign fire_o  = rst_hit && rst_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      irq_flag_q <= 1'b0;
      rst_flag_q <= 1'b0;
      pulse_q    <= 1'b0;
    end else begin
      if (restart_i || fire_o) cnt_q <= '0;
      else                     cnt_q <= cnt_q + 1'b1;
      // set beats write-one-to-clear
      if (irq_hit)        irq_flag_q <= 1'b1;
      else if (clr_irq_i) irq_flag_q <= 1'b0;
      if (rst_hit)        rst_flag_q <= 1'b1;
      else if (clr_rst_i) rst_flag_q <= 1'b0;
      pulse_q <= fire_o;
    end
  end

  assign irq_flag_o = irq_flag_q;
  assign rst_flag_o = rst_flag_q;
  assign wdt_rst_o  = pulse_q;

  // R4
  pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |=> !wdt_rst_o);

  // R4
  pulse_clears_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |-> (cnt_q == '0) && rst_flag_q);

  // R5
  restart_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (cnt_q == '0) && !wdt_rst_o);
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int SCALE = 0,
  parameter int GAP   = 512,
  parameter int WIN   = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [1:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  output logic       irq_o,
  output logic       irq_flag_o,
  output logic       rst_flag_o,
  output logic       rst_en_o,
  output logic       wdt_rst_o
);
  logic [1:0] sel_q;
  logic       irq_en_q, rst_en_q;
  logic       win_open, prot_wr, clr_wr, fire;
  logic       irq_flag, rst_flag;

  wdog_unlock #(.WIN(WIN)) u_unlock (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .open_o    (win_open)
  );

  assign prot_wr = win_open && wr_en_i && (wr_addr_i == ADDR_PROT);
  assign clr_wr  = wr_en_i && (wr_addr_i == ADDR_CLR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q    <= 2'd0;
      irq_en_q <= 1'b0;
      rst_en_q <= 1'b0;
    end else begin
      if (wr_en_i && (wr_addr_i == ADDR_CFG)) begin
        sel_q    <= wr_data_i[1:0];
        irq_en_q <= wr_data_i[2];
      end
      if (fire)                 rst_en_q <= 1'b0;
      else if (prot_wr) begin
        if (wr_data_i[2])      rst_en_q <= 1'b0;
        else if (wr_data_i[1]) rst_en_q <= 1'b1;
      end
    end
  end

  wdog_timer #(.SCALE(SCALE), .GAP(GAP)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (sel_q),
    .restart_i  (prot_wr && wr_data_i[0]),
    .rst_en_i   (rst_en_q),
    .clr_irq_i  (clr_wr && wr_data_i[0]),
    .clr_rst_i  (clr_wr && wr_data_i[1]),
    .fire_o     (fire),
    .irq_flag_o (irq_flag),
    .rst_flag_o (rst_flag),
    .wdt_rst_o  (wdt_rst_o)
  );

  assign irq_o      = irq_flag && irq_en_q;
  assign irq_flag_o = irq_flag;
  assign rst_flag_o = rst_flag;
  assign rst_en_o   = rst_en_q;

  // R3
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> irq_en_q && irq_flag_o);

  // R6
  arm_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rst_en_q) |-> $past(prot_wr) || $past(fire));

  // R4
  pulse_needs_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wdt_rst_o) |-> $past(rst_en_q) && !rst_en_q);
endmodule

// File: tb/wdog_top_tb_top.sv
`timescale 1ns/1ps
module wdog_top_tb_top;
  localparam int SCALE = 12;
  localparam int GAP   = 512;
  localparam int K_IRQ = 0, K_RFL = 1, K_PUL = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       irq, irq_flag, rst_flag, rst_en, wdt_rst;

  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;

  typedef struct { int kind; int at; } ev_t;
  ev_t exp_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdog_top #(.SCALE(SCALE), .GAP(GAP), .WIN(3)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .irq_o(irq), .irq_flag_o(irq_flag),
    .rst_flag_o(rst_flag), .rst_en_o(rst_en), .wdt_rst_o(wdt_rst)
  );

  function automatic string req_of(int k);
    return (k == K_IRQ) ? "R1" : (k == K_RFL) ? "R2" : "R4";
  endfunction

  task automatic check(string req, logic got, logic want);
    n_cmp++;
    if (got !== want) begin
      n_bad++;
      $display("FAIL %s: actual=%0b expected=%0b at cycle %0d", req, got, want, cyc);
    end
  endtask

  task automatic push(int kind, int at);
    ev_t e; e.kind = kind; e.at = at; exp_q.push_back(e);
  endtask

  task automatic take(int kind);
    ev_t e;
    n_cmp++;
    if (exp_q.size() == 0) begin
      n_bad++;
      $display("FAIL %s: actual=event%0d@%0d expected=none", req_of(kind), kind, cyc);
    end else begin
      e = exp_q.pop_front();
      if (e.kind != kind || e.at != cyc) begin
        n_bad++;
        $display("FAIL %s: actual=event%0d@%0d expected=event%0d@%0d",
                 req_of(e.kind), kind, cyc, e.kind, e.at);
      end
    end
  endtask

  // monitor: flag rises and pulses compared with the expected queue
  initial begin
    logic p_irq = 1'b0, p_rfl = 1'b0;
    forever begin
      @(negedge clk);
      if (mon_on) begin
        if (irq_flag && !p_irq) take(K_IRQ);
        if (rst_flag && !p_rfl) take(K_RFL);
        if (wdt_rst)            take(K_PUL);
      end
      p_irq = irq_flag;
      p_rfl = rst_flag;
    end
  end

  task automatic wr(logic [1:0] a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'd0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic unlock();
    wr(2'd0, 8'hAA);
    wr(2'd0, 8'h55);
  endtask

  task automatic restart(output int t0);
    unlock();
    t0 = cyc + 1;
    wr(2'd2, 8'h01);
  endtask

  task automatic wait_at(int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      report();
    end
  end

  initial begin
    int t0, t1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check("R9", irq_flag, 1'b0); check("R9", rst_flag, 1'b0);
    check("R9", irq, 1'b0);      check("R9", wdt_rst, 1'b0);
    check("R9", rst_en, 1'b0);
    mon_on = 1'b1;

    // R1 R2 R3: select 0, interrupt enabled, reset not armed
    wr(2'd1, 8'h04);
    restart(t0);
    push(K_IRQ, t0 + 32); push(K_RFL, t0 + 32 + GAP);
    drain();
    check("R3", irq, 1'b1);
    wr(2'd3, 8'h03);
    check("R8", irq_flag, 1'b0); check("R8", rst_flag, 1'b0); check("R3", irq, 1'b0);

    // R8 set wins over clear in the same clock
    restart(t0);
    push(K_IRQ, t0 + 32); push(K_RFL, t0 + 32 + GAP);
    wait_at(t0 + 31);
    wr(2'd3, 8'h01);
    check("R8", irq_flag, 1'b1);
    drain();
    wr(2'd3, 8'h03);

    // R6: protected writes without unlock are ignored
    wr(2'd2, 8'h02);
    check("R6", rst_en, 1'b0);
    wr(2'd1, 8'h05);
    restart(t0);
    push(K_IRQ, t0 + 256); push(K_RFL, t0 + 256 + GAP);
    wait_at(t0 + 100);
    wr(2'd2, 8'h01);
    drain();
    wr(2'd3, 8'h03);

    // R7: window rules
    unlock(); wr(2'd1, 8'h05); wr(2'd2, 8'h02);
    check("R7", rst_en, 1'b0);
    unlock(); idle(2); wr(2'd2, 8'h02);
    check("R7", rst_en, 1'b1);
    unlock(); wr(2'd2, 8'h06);
    check("R10", rst_en, 1'b0);
    unlock(); idle(3); wr(2'd2, 8'h02);
    check("R7", rst_en, 1'b0);
    wr(2'd0, 8'hAA); idle(1); wr(2'd0, 8'h55); wr(2'd2, 8'h02);
    check("R7", rst_en, 1'b0);

    // R4: armed expiry gives one pulse, clears counter and arm bit
    wr(2'd1, 8'h04);
    unlock(); wr(2'd2, 8'h02);
    check("R10", rst_en, 1'b1);
    restart(t0);
    push(K_IRQ, t0 + 32); push(K_RFL, t0 + 32 + GAP); push(K_PUL, t0 + 32 + GAP);
    drain();
    check("R4", rst_en, 1'b0);
    check("R4", wdt_rst, 1'b1);
    @(negedge clk);
    check("R4", wdt_rst, 1'b0);
    wr(2'd3, 8'h03);
    t1 = t0 + 32 + GAP;
    push(K_IRQ, t1 + 32); push(K_RFL, t1 + 32 + GAP);
    drain();
    wr(2'd3, 8'h03);

    // R5: restart mid-count starts a full interval again
    restart(t0);
    wait_at(t0 + 20);
    restart(t1);
    push(K_IRQ, t1 + 32); push(K_RFL, t1 + 32 + GAP);
    drain();
    wr(2'd3, 8'h03);

    // R1 select 2 with interrupt disabled (R3)
    wr(2'd1, 8'h02);
    restart(t0);
    push(K_IRQ, t0 + 2048); push(K_RFL, t0 + 2048 + GAP);
    drain();
    check("R3", irq_flag, 1'b1); check("R3", irq, 1'b0);
    wr(2'd3, 8'h03);

    // R1 select 3
    wr(2'd1, 8'h03);
    restart(t0);
    push(K_IRQ, t0 + 16384); push(K_RFL, t0 + 16384 + GAP);
    drain();
    check("R2", rst_flag, 1'b1);
    idle(4);
    done = 1'b1;
    report();
  end
endmodule